// File: doc/BRIEF.md
# Conditional Branch and Loop Decision Unit

This block sits in the branch stage of an integer pipeline. For each valid operation it decides whether a near relative transfer is taken and produces the instruction pointer that fetch should continue from. Three kinds of operation are handled. The first is a flag-conditioned jump that selects one of sixteen conditions over the carry, zero, sign, overflow and parity flags. The second is a jump taken when the count register is zero. The third is a family of three loop operations: each decrements the count register and branches on the new value, and two of them also require the zero flag to be set or clear.

All decision logic is combinational. The taken flag, the next pointer and the updated count are captured in one register stage, so a result appears on the clock edge after the operation is presented. An address-size input narrows every count test, and every loop decrement, to the low 16 bits of the count. The upper half of the count is then left untouched. Flag generation and far transfers are handled elsewhere.

Top module: `br_loop_unit`

## Requirements
- R1: With op_i = 1 the taken decision follows cc_i: 0 OF=1, 1 OF=0, 2 CF=1, 3 CF=0, 4 ZF=1, 5 ZF=0, 6 CF|ZF=1, 7 CF|ZF=0, 8 SF=1, 9 SF=0, 10 PF=1, 11 PF=0, 12 SF^OF=1, 13 SF^OF=0, 14 (SF^OF)|ZF=1, 15 (SF^OF)|ZF=0.
- R2: For op_i = 1, bit 0 of cc_i complements the condition selected by cc_i[3:1]: codes 2k and 2k+1 never give the same decision for the same flags.
- R3: A taken operation yields nip_o = nip_i + disp_i, where disp_i is two's complement and the sum wraps modulo 2^AW. A not-taken operation yields nip_o = nip_i.
- R4: With op_i = 2 the transfer is taken exactly when the count is zero. The count is cnt_i[15:0] when addr16_i = 1 and the full cnt_i otherwise. No flag affects the decision, and cnt_o equals cnt_i.
- R5: With op_i = 3 the count is decremented first: cnt_o = cnt_i - 1, and the branch is taken only if that result is nonzero. A count of zero wraps to all ones, and the branch is taken.
- R6: With op_i = 4 the count is decremented as in R5, and the branch is taken only when the decremented count is nonzero and ZF = 1.
- R7: With op_i = 5 the count is decremented as in R5, and the branch is taken only when the decremented count is nonzero and ZF = 0.
- R8: For op_i 3, 4 and 5 with addr16_i = 1, only cnt_i[15:0] is decremented and tested, wrapping 0 to FFFFh. cnt_o[31:16] equals cnt_i[31:16].
- R9: When valid_i is high on a clock edge, vld_o is high after that edge and carries the result. A cycle without valid_i gives vld_o = 0, and taken_o, nip_o and cnt_o keep their previous values.
- R10: While reset is held, vld_o, taken_o, nip_o and cnt_o are all zero.
- R11: op_i values 0, 6 and 7 are never taken for any flags or count. They give nip_o = nip_i and cnt_o = cnt_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation: 0 none, 1 flag jump, 2 count-zero jump, 3 loop, 4 loop-while-zero, 5 loop-while-not-zero, 6/7 none |
| cc_i | input | 4 | Condition code for op_i = 1 |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| pf_i | input | 1 | Parity flag |
| addr16_i | input | 1 | 16-bit address size: narrows count tests and decrements |
| cnt_i | input | CW | Count register value |
| nip_i | input | AW | Pointer of the following instruction |
| disp_i | input | AW | Signed displacement |
| vld_o | output | 1 | Result valid |
| taken_o | output | 1 | Transfer taken |
| nip_o | output | AW | Next instruction pointer |
| cnt_o | output | CW | Updated count register value |

## Verification
The assertions assume that every input is at a known value whenever valid_i is high. They also assume that the internally synchronised reset gates every check, so a property that starts while reset is active is discarded. The stimulus drives all inputs on the falling clock edge and holds them at zero throughout reset. It uses only the defined op_i codes and the two reserved codes, and it steps the condition code through all sixteen values against every combination of the five flags.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [2:0] {
    BR_NONE   = 3'd0,
    BR_JCC    = 3'd1,
    BR_JCZ    = 3'd2,
    BR_LOOP   = 3'd3,
    BR_LOOPZ  = 3'd4,
    BR_LOOPNZ = 3'd5,
    BR_RSV6   = 3'd6,
    BR_RSV7   = 3'd7
  } br_op_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } br_flags_t;

endpackage

// File: rtl/br_rst_sync.sv
module br_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  br_flags_t   flags_i,
  input  logic [3:0]  cc_i,
  output logic        met_o
);

  logic base;
  logic lt;

  assign lt = flags_i.sf ^ flags_i.of;

  // cc_i[3:1] picks the base test, cc_i[0] negates it
  always_comb begin
    case (cc_i[3:1])
      3'd0:    base = flags_i.of;
      3'd1:    base = flags_i.cf;
      3'd2:    base = flags_i.zf;
      3'd3:    base = flags_i.cf | flags_i.zf;
      3'd4:    base = flags_i.sf;
      3'd5:    base = flags_i.pf;
      3'd6:    base = lt;
      default: base = lt | flags_i.zf;
    endcase
  end

  assign met_o = base ^ cc_i[0];

endmodule

// File: rtl/br_count_unit.sv
module br_count_unit #(
  parameter int CW = 32,
  parameter int NW = 16
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          narrow_i,
  output logic [CW-1:0] dec_o,
  output logic          cnt_zero_o,
  output logic          dec_nz_o
);

  localparam logic [CW-1:0] ONE_W = CW'(1);
  localparam logic [NW-1:0] ONE_N = NW'(1);

  logic [CW-1:0] wide_dec;
  logic [CW-1:0] narrow_dec;

  assign wide_dec = cnt_i - ONE_W;

  generate
    if (NW < CW) begin : g_split
      // narrow mode: decrement low part, keep the upper part
      assign narrow_dec = {cnt_i[CW-1:NW], cnt_i[NW-1:0] - ONE_N};
    end else begin : g_full
      assign narrow_dec = wide_dec;
    end
  endgenerate

  assign dec_o      = narrow_i ? narrow_dec : wide_dec;
  assign cnt_zero_o = narrow_i ? (cnt_i[NW-1:0] == '0) : (cnt_i == '0);
  assign dec_nz_o   = narrow_i ? (|dec_o[NW-1:0]) : (|dec_o);

endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] nip_i,
  input  logic [AW-1:0] disp_i,
  input  logic          take_i,
  output logic [AW-1:0] next_o
);

  logic [AW-1:0] sum;

  // two's complement add: negative displacements wrap naturally
  assign sum    = nip_i + disp_i;
  assign next_o = take_i ? sum : nip_i;

endmodule

// File: rtl/br_loop_unit.sv
module br_loop_unit
  import br_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [3:0]    cc_i,
  input  logic          cf_i,
  input  logic          zf_i,
  input  logic          sf_i,
  input  logic          of_i,
  input  logic          pf_i,
  input  logic          addr16_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] nip_i,
  input  logic [AW-1:0] disp_i,
  output logic          vld_o,
  output logic          taken_o,
  output logic [AW-1:0] nip_o,
  output logic [CW-1:0] cnt_o
);

  logic          rst_s_n;
  br_op_e        op;
  br_flags_t     flags;
  logic          cc_met;
  logic [CW-1:0] cnt_dec;
  logic          cnt_zero;
  logic          dec_nz;
  logic          take_d;
  logic [CW-1:0] cnt_d;
  logic [AW-1:0] nip_d;

  logic          vld_q;
  logic          taken_q;
  logic [AW-1:0] nip_q;
  logic [CW-1:0] cnt_q;

  br_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s_n)
  );

  assign op       = br_op_e'(op_i);
  assign flags.cf = cf_i;
  assign flags.zf = zf_i;
  assign flags.sf = sf_i;
  assign flags.of = of_i;
  assign flags.pf = pf_i;

  br_cond_eval i_cond (
    .flags_i (flags),
    .cc_i    (cc_i),
    .met_o   (cc_met)
  );

  br_count_unit #(
    .CW (CW),
    .NW (NW)
  ) i_count (
    .cnt_i      (cnt_i),
    .narrow_i   (addr16_i),
    .dec_o      (cnt_dec),
    .cnt_zero_o (cnt_zero),
    .dec_nz_o   (dec_nz)
  );

  // next-state decision
  always_comb begin
    take_d = 1'b0;
    cnt_d  = cnt_i;
    case (op)
      BR_JCC:    take_d = cc_met;
      BR_JCZ:    take_d = cnt_zero;
      BR_LOOP: begin
        take_d = dec_nz;
        cnt_d  = cnt_dec;
      end
      BR_LOOPZ: begin
        take_d = dec_nz & zf_i;
        cnt_d  = cnt_dec;
      end
      BR_LOOPNZ: begin
        take_d = dec_nz & ~zf_i;
        cnt_d  = cnt_dec;
      end
      default: begin
        take_d = 1'b0;
        cnt_d  = cnt_i;
      end
    endcase
  end

  br_target #(
    .AW (AW)
  ) i_target (
    .nip_i  (nip_i),
    .disp_i (disp_i),
    .take_i (take_d),
    .next_o (nip_d)
  );

  // output register stage
  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      taken_q <= 1'b0;
      nip_q   <= '0;
      cnt_q   <= '0;
    end else if (valid_i) begin
      taken_q <= take_d;
      nip_q   <= nip_d;
      cnt_q   <= cnt_d;
    end
  end

  assign vld_o   = vld_q;
  assign taken_o = taken_q;
  assign nip_o   = nip_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/br_loop_unit_chk.sv
module br_loop_unit_chk
  import br_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_s_n,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic          zf_i,
  input  logic          addr16_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] nip_i,
  input  logic [AW-1:0] disp_i,
  input  logic          vld_o,
  input  logic          taken_o,
  input  logic [AW-1:0] nip_o,
  input  logic [CW-1:0] cnt_o
);

  logic is_loop;
  logic keeps_cnt;

  assign is_loop   = (op_i == BR_LOOP) || (op_i == BR_LOOPZ) || (op_i == BR_LOOPNZ);
  assign keeps_cnt = !is_loop;

  assert_reset_outputs_R10: assert property (@(posedge clk_i)
    !rst_s_n |-> (!vld_o && !taken_o && nip_o == '0 && cnt_o == '0));

  assert_valid_result_R9: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    valid_i |=> vld_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    !valid_i |=> (!vld_o && $stable(taken_o) && $stable(nip_o) && $stable(cnt_o)));

  assert_target_R3: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    valid_i |=> (taken_o ? (nip_o == $past(nip_i + disp_i)) : (nip_o == $past(nip_i))));

  assert_count_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (valid_i && keeps_cnt) |=> (cnt_o == $past(cnt_i)));

  assert_upper_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (valid_i && addr16_i) |=> (cnt_o[CW-1:NW] == $past(cnt_i[CW-1:NW])));

  assert_loop_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (valid_i && is_loop && !addr16_i) |=> (!taken_o || cnt_o != '0));

  assert_loopz_needs_zf_R6: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (valid_i && op_i == BR_LOOPZ && !zf_i) |=> !taken_o);

  assert_loopnz_needs_nzf_R7: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (valid_i && op_i == BR_LOOPNZ && zf_i) |=> !taken_o);

  assert_reserved_not_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (valid_i && (op_i == BR_NONE || op_i == BR_RSV6 || op_i == BR_RSV7)) |=> !taken_o);

endmodule

bind br_loop_unit br_loop_unit_chk #(
  .AW (AW),
  .CW (CW),
  .NW (NW)
) i_br_loop_unit_chk (
  .clk_i    (clk_i),
  .rst_s_n  (rst_s_n),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .zf_i     (zf_i),
  .addr16_i (addr16_i),
  .cnt_i    (cnt_i),
  .nip_i    (nip_i),
  .disp_i   (disp_i),
  .vld_o    (vld_o),
  .taken_o  (taken_o),
  .nip_o    (nip_o),
  .cnt_o    (cnt_o)
);

// File: tb/test_br_loop_unit.sv
`timescale 1ns/1ps
module test_br_loop_unit;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [3:0]  cc_i;
  logic        cf_i, zf_i, sf_i, of_i, pf_i;
  logic        addr16_i;
  logic [31:0] cnt_i, nip_i, disp_i;
  logic        vld_o, taken_o;
  logic [31:0] nip_o, cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  typedef struct packed {
    logic        taken;
    logic [31:0] nip;
    logic [31:0] cnt;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk_i = ~clk_i;

  br_loop_unit i_br_loop_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .cc_i,
    .cf_i, .zf_i, .sf_i, .of_i, .pf_i,
    .addr16_i, .cnt_i, .nip_i, .disp_i,
    .vld_o, .taken_o, .nip_o, .cnt_o
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // flag condition table from R1
  function automatic logic cond_model(input logic [3:0] cc, input logic [4:0] f);
    logic cf, zf, sf, of, pf;
    {pf, of, sf, zf, cf} = f;
    case (cc)
      4'd0:  return of;
      4'd1:  return !of;
      4'd2:  return cf;
      4'd3:  return !cf;
      4'd4:  return zf;
      4'd5:  return !zf;
      4'd6:  return cf | zf;
      4'd7:  return !(cf | zf);
      4'd8:  return sf;
      4'd9:  return !sf;
      4'd10: return pf;
      4'd11: return !pf;
      4'd12: return sf ^ of;
      4'd13: return !(sf ^ of);
      4'd14: return (sf ^ of) | zf;
      default: return !((sf ^ of) | zf);
    endcase
  endfunction

  // driver: presents one operation and queues its expected result
  task automatic send(input logic [2:0] op, input logic [3:0] cc, input logic [4:0] f,
                      input logic [31:0] cnt, input logic [31:0] nip,
                      input logic [31:0] disp, input logic a16, input string tag);
    exp_t        e;
    logic        t;
    logic [31:0] d;
    logic        nz;
    @(negedge clk_i);
    valid_i  = 1'b1;
    op_i     = op;
    cc_i     = cc;
    {pf_i, of_i, sf_i, zf_i, cf_i} = f;
    cnt_i    = cnt;
    nip_i    = nip;
    disp_i   = disp;
    addr16_i = a16;
    d  = a16 ? {cnt[31:16], cnt[15:0] - 16'd1} : cnt - 32'd1;
    nz = a16 ? (d[15:0] != 16'd0) : (d != 32'd0);
    e.cnt = cnt;
    case (op)
      3'd1: t = cond_model(cc, f);
      3'd2: t = a16 ? (cnt[15:0] == 16'd0) : (cnt == 32'd0);
      3'd3: begin t = nz;          e.cnt = d; end
      3'd4: begin t = nz && f[1];  e.cnt = d; end
      3'd5: begin t = nz && !f[1]; e.cnt = d; end
      default: t = 1'b0;
    endcase
    e.taken = t;
    e.nip   = t ? nip + disp : nip;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      op_i    = 3'd3;
      cnt_i   = 32'hDEAD_0000 + i;
      nip_i   = 32'h5555_0000 + i;
    end
  endtask

  // monitor: compares each valid result against the scoreboard
  always @(negedge clk_i) begin
    if (mon_on && vld_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected vld_o", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(taken_o == e.taken, tg, "taken_o", {31'd0, taken_o}, {31'd0, e.taken});
        check(nip_o == e.nip, tg, "nip_o (R3)", nip_o, e.nip);
        check(cnt_o == e.cnt, tg, "cnt_o", cnt_o, e.cnt);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_nip, hold_cnt;
    logic        hold_tk;
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; cc_i = '0;
    {pf_i, of_i, sf_i, zf_i, cf_i} = '0;
    addr16_i = 1'b0; cnt_i = '0; nip_i = '0; disp_i = '0;
    repeat (4) @(negedge clk_i);
    // R10: reset state
    check(vld_o == 1'b0 && taken_o == 1'b0, "R10", "vld/taken in reset", {30'd0, vld_o, taken_o}, 32'd0);
    check(nip_o == 32'd0, "R10", "nip_o in reset", nip_o, 32'd0);
    check(cnt_o == 32'd0, "R10", "cnt_o in reset", cnt_o, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    mon_on = 1'b1;

    // R1 / R2: every condition code against every flag combination
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        send(3'd1, 4'(c), 5'(f), 32'h0000_0007, 32'h0010_0000 + 32'(c * 64 + f),
             (f[0] ? 32'hFFFF_FF80 : 32'h0000_0040), 1'b0, (c % 2 == 0) ? "R1" : "R2");
      end
    end
    // R3: wrap-around of the target
    send(3'd1, 4'd4, 5'b00010, 32'd0, 32'hFFFF_FFF0, 32'h0000_0020, 1'b0, "R3");
    send(3'd1, 4'd4, 5'b00010, 32'd0, 32'h0000_0010, 32'hFFFF_FFE0, 1'b0, "R3");

    // R4: count-zero jump, both widths, flags irrelevant
    send(3'd2, 4'd0, 5'b11111, 32'h0000_0000, 32'h100, 32'h10, 1'b0, "R4");
    send(3'd2, 4'd0, 5'b00000, 32'h0001_0000, 32'h100, 32'h10, 1'b0, "R4");
    send(3'd2, 4'd0, 5'b10101, 32'h0001_0000, 32'h100, 32'h10, 1'b1, "R4");
    send(3'd2, 4'd0, 5'b01010, 32'h0000_0001, 32'h100, 32'h10, 1'b1, "R4");

    // R5: plain loop including zero wrap
    send(3'd3, 4'd0, 5'b00000, 32'd5, 32'h200, 32'hFFFF_FFF8, 1'b0, "R5");
    send(3'd3, 4'd0, 5'b11111, 32'd1, 32'h200, 32'hFFFF_FFF8, 1'b0, "R5");
    send(3'd3, 4'd0, 5'b00000, 32'd0, 32'h200, 32'hFFFF_FFF8, 1'b0, "R5");
    send(3'd3, 4'd0, 5'b00000, 32'h0001_0000, 32'h200, 32'hFFFF_FFF8, 1'b0, "R5");

    // R6: loop while zero flag set
    send(3'd4, 4'd0, 5'b00010, 32'd9, 32'h300, 32'hFFFF_FF00, 1'b0, "R6");
    send(3'd4, 4'd0, 5'b00000, 32'd9, 32'h300, 32'hFFFF_FF00, 1'b0, "R6");
    send(3'd4, 4'd0, 5'b00010, 32'd1, 32'h300, 32'hFFFF_FF00, 1'b0, "R6");
    send(3'd4, 4'd0, 5'b00010, 32'd0, 32'h300, 32'hFFFF_FF00, 1'b0, "R6");

    // R7: loop while zero flag clear
    send(3'd5, 4'd0, 5'b00000, 32'd9, 32'h400, 32'h0000_0100, 1'b0, "R7");
    send(3'd5, 4'd0, 5'b00010, 32'd9, 32'h400, 32'h0000_0100, 1'b0, "R7");
    send(3'd5, 4'd0, 5'b11101, 32'd1, 32'h400, 32'h0000_0100, 1'b0, "R7");
    send(3'd5, 4'd0, 5'b00000, 32'd0, 32'h400, 32'h0000_0100, 1'b0, "R7");

    // R8: narrow count in loops
    send(3'd3, 4'd0, 5'b00000, 32'hABCD_0000, 32'h500, 32'h8, 1'b1, "R8");
    send(3'd3, 4'd0, 5'b00000, 32'h1234_0001, 32'h500, 32'h8, 1'b1, "R8");
    send(3'd4, 4'd0, 5'b00010, 32'hFFFF_0005, 32'h500, 32'h8, 1'b1, "R8");
    send(3'd5, 4'd0, 5'b00000, 32'h8000_0001, 32'h500, 32'h8, 1'b1, "R8");

    // R11: no-operation and reserved codes
    send(3'd0, 4'd7, 5'b11111, 32'h0000_0000, 32'h600, 32'h40, 1'b0, "R11");
    send(3'd6, 4'd5, 5'b00000, 32'h0000_0001, 32'h600, 32'h40, 1'b1, "R11");
    send(3'd7, 4'd3, 5'b00010, 32'h0000_0000, 32'h600, 32'h40, 1'b0, "R11");

    // R9: idle cycles keep the last result
    idle(1);
    @(negedge clk_i);
    hold_nip = nip_o; hold_cnt = cnt_o; hold_tk = taken_o;
    idle(3);
    @(negedge clk_i);
    check(vld_o == 1'b0, "R9", "vld_o idle", {31'd0, vld_o}, 32'd0);
    check(nip_o == hold_nip, "R9", "nip_o held", nip_o, hold_nip);
    check(cnt_o == hold_cnt && taken_o == hold_tk, "R9", "cnt_o held", cnt_o, hold_cnt);
    check(exp_q.size() == 0, "R9", "results outstanding", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule